// File: doc/BRIEF.md
# Oversampled serial receiver with start-bit validation

This block receives asynchronous serial frames on a single line and turns them into parallel words of 7, 8 or 9 bits. The line is resynchronised into the clock domain first. A falling edge seen while the receiver is enabled and idle opens a start check. The line is sampled again half a bit later. Only a low sample there commits the receiver to the frame. A high sample means the edge was a glitch: the receiver raises a sticky noise flag, drops the attempt and waits for the next falling edge.

Once a start bit is accepted, each data bit and then the stop bit is sampled at the centre of its bit period. Bit periods are counted in ticks of an external 16x oversampling strobe. The word is presented on a data output with a one-cycle valid strobe. A low stop bit raises a sticky framing flag, and the word is still delivered. Baud rate generation, parity, buffering and low-power wake-up belong to other blocks.

Top module: `rx_frame_validator`

## Requirements
- R1: While rst_ni is low, and right after it is released, data_o is zero and data_valid_o, noise_err_o and frame_err_o are low.
- R2: rx_i passes through two flops before use. A falling edge of the synchronised line starts a start-bit check only while the receiver is enabled and idle.
- R3: The line is sampled on the 8th tick_i after the start check begins. If that sample is high, noise_err_o is set, no word is delivered, and the receiver returns to idle.
- R4: If the mid-start sample is low, each data bit is sampled every 16 ticks after that point, least significant bit first. Bit k is written to data_o[k].
- R5: word_len_i selects the word length when the start bit is accepted: 0 gives 7 bits, 1 gives 8, 2 gives 9 and 3 gives 8. data_o bits at or above the length are zero.
- R6: The stop bit is sampled 16 ticks after the last data bit. In the following cycle data_valid_o is high for exactly one cycle, and data_o holds the word until the next delivery.
- R7: A low stop-bit sample sets frame_err_o in the same cycle that the word is delivered with data_valid_o.
- R8: noise_err_o and frame_err_o stay set until err_clr_i is high at a clock edge. A new error in that same cycle wins over the clear.
- R9: While rx_en_i is low, the receiver is held idle. A frame in progress is abandoned without delivering a word, and falling edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Receive enable |
| word_len_i | input | 2 | Word length select (0:7, 1:8, 2:9, 3:8) |
| tick_i | input | 1 | Oversampling strobe, 16 per bit |
| err_clr_i | input | 1 | Clears both error flags |
| data_o | output | MAX_BITS | Last received word |
| data_valid_o | output | 1 | One-cycle strobe for a new word |
| noise_err_o | output | 1 | Sticky rejected-start flag |
| frame_err_o | output | 1 | Sticky low-stop-bit flag |

## Verification
The bench builds the block with its defaults: 16 ticks per bit, a 9-bit maximum word and two synchroniser stages. It issues a tick every fourth clock, so one bit lasts 64 clocks. Every word-length code is reachable, including the 9th data bit and the code-3 alias. A short low pulse of 12 clocks ends before the mid-start sample and exercises the rejected-start path. The bench also drops the enable in the middle of a frame, keeps it low for a whole frame, and sends a low stop bit. In all of these cases the cycle model's timing of strobes and flags is compared on every clock.

// File: rtl/rxv_pkg.sv
package rxv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_e;

  function automatic int len_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return 7;
      2'd2:    return 9;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/rxv_sync.sv
module rxv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_o,
  output logic fall_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], rx_i};
      prev_q <= sr_q[STAGES-1];
    end
  end

  assign rx_o   = sr_q[STAGES-1];
  assign fall_o = prev_q & ~sr_q[STAGES-1];
endmodule

// File: rtl/rxv_os_cnt.sv
module rxv_os_cnt #(
  parameter int OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic half_o,
  output logic full_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] HALF = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign half_o = tick_i && (cnt_q == HALF);
  assign full_o = tick_i && (cnt_q == LAST);
endmodule

// File: rtl/rxv_assembler.sv
module rxv_assembler #(
  parameter int MAX_BITS = 9,
  localparam int IW = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [IW-1:0]       len_i,
  input  logic                shift_i,
  input  logic                bit_i,
  output logic [MAX_BITS-1:0] word_o,
  output logic                last_o
);
  logic [MAX_BITS-1:0] word_q;
  logic [IW-1:0]       idx_q;
  logic [IW-1:0]       len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      idx_q  <= '0;
      len_q  <= IW'(MAX_BITS);
    end else if (load_i) begin
      word_q <= '0;
      idx_q  <= '0;
      len_q  <= len_i;
    end else if (shift_i) begin
      for (int i = 0; i < MAX_BITS; i++)
        if (idx_q == IW'(i)) word_q[i] <= bit_i;
      idx_q <= idx_q + 1'b1;
    end
  end

  assign word_o = word_q;
  assign last_o = (idx_q == len_q - 1'b1);

  // R5
  idx_in_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> (idx_q < len_q));
endmodule

// File: rtl/rx_frame_validator.sv
module rx_frame_validator
  import rxv_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int MAX_BITS    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_i,
  input  logic                rx_en_i,
  input  logic [1:0]          word_len_i,
  input  logic                tick_i,
  input  logic                err_clr_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic                data_valid_o,
  output logic                noise_err_o,
  output logic                frame_err_o
);
  localparam int IW = $clog2(MAX_BITS + 1);

  rx_state_e           state_q, state_d;
  logic                rx_s, rx_fall;
  logic                half_hit, full_hit, cnt_clr;
  logic                asm_load, asm_shift, last_bit;
  logic [MAX_BITS-1:0] word;
  logic                set_noise, set_frame, deliver;

  rxv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_i  (rx_i),
    .rx_o  (rx_s),
    .fall_o(rx_fall)
  );

  rxv_os_cnt #(.OSR(OSR)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .tick_i(tick_i),
    .half_o(half_hit),
    .full_o(full_hit)
  );

  rxv_assembler #(.MAX_BITS(MAX_BITS)) u_asm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (asm_load),
    .len_i  (IW'(len_of(word_len_i))),
    .shift_i(asm_shift),
    .bit_i  (rx_s),
    .word_o (word),
    .last_o (last_bit)
  );

  always_comb begin
    state_d   = state_q;
    asm_load  = 1'b0;
    asm_shift = 1'b0;
    set_noise = 1'b0;
    set_frame = 1'b0;
    deliver   = 1'b0;
    if (!rx_en_i) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:  if (rx_fall) state_d = ST_START;
        ST_START: if (half_hit) begin
          if (rx_s) begin
            set_noise = 1'b1;
            state_d   = ST_IDLE;
          end else begin
            asm_load = 1'b1;
            state_d  = ST_DATA;
          end
        end
        ST_DATA:  if (full_hit) begin
          asm_shift = 1'b1;
          if (last_bit) state_d = ST_STOP;
        end
        ST_STOP:  if (full_hit) begin
          deliver   = 1'b1;
          set_frame = ~rx_s;
          state_d   = ST_IDLE;
        end
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  // counter restarts at the edge and again at the confirmed mid-start point
  assign cnt_clr = !rx_en_i || (state_q == ST_IDLE) || (state_q == ST_START && half_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      data_o       <= '0;
      data_valid_o <= 1'b0;
      noise_err_o  <= 1'b0;
      frame_err_o  <= 1'b0;
    end else begin
      state_q      <= state_d;
      data_valid_o <= deliver;
      if (deliver) data_o <= word;
      if (set_noise)      noise_err_o <= 1'b1;
      else if (err_clr_i) noise_err_o <= 1'b0;
      if (set_frame)      frame_err_o <= 1'b1;
      else if (err_clr_i) frame_err_o <= 1'b0;
    end
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |=> !data_valid_o);
  // R8
  noise_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (noise_err_o && !err_clr_i) |=> noise_err_o);
  // R8
  frame_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_err_o && !err_clr_i) |=> frame_err_o);
  // R3
  noise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(noise_err_o) |-> ($past(state_q) == ST_START));
  // R7
  frame_with_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_err_o) |-> data_valid_o);
  // R9
  disable_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> (state_q == ST_IDLE));
endmodule

// File: tb/rx_frame_validator_tb.sv
module rx_frame_validator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLK    = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_b = 1'b1;
  logic       en_b = 1'b0;
  logic [1:0] len_b = 2'd1;
  logic       tick_b = 1'b0;
  logic       clr_b = 1'b0;
  logic [8:0] data_o;
  logic       valid_o, noise_o, frame_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  rx_frame_validator u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx_b), .rx_en_i(en_b),
    .word_len_i(len_b), .tick_i(tick_b), .err_clr_i(clr_b),
    .data_o(data_o), .data_valid_o(valid_o),
    .noise_err_o(noise_o), .frame_err_o(frame_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // tick strobe
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv   = (tdiv + 1) % TICK_DIV;
    tick_b = (tdiv == 0);
  end

  // behavioural reference
  int m_s1, m_s2, m_prev, m_st, m_cnt, m_idx, m_len, m_word, m_out, m_valid, m_ne, m_fe;
  function automatic int lmap(input logic [1:0] s);
    return (s == 2'd0) ? 7 : (s == 2'd2) ? 9 : 8;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_prev = 1; m_st = 0; m_cnt = 0; m_idx = 0;
      m_len = 9; m_word = 0; m_out = 0; m_valid = 0; m_ne = 0; m_fe = 0;
    end else begin
      bit fall, sn, sf;
      fall = (m_prev == 1) && (m_s2 == 0);
      sn = 0; sf = 0; m_valid = 0;
      if (!en_b) begin
        m_st = 0; m_cnt = 0;
      end else if (m_st == 0) begin
        m_cnt = 0;
        if (fall) m_st = 1;
      end else if (tick_b) begin
        if (m_st == 1) begin
          if (m_cnt == 7) begin
            m_cnt = 0;
            if (m_s2 == 1) begin sn = 1; m_st = 0; end
            else begin m_st = 2; m_idx = 0; m_word = 0; m_len = lmap(len_b); end
          end else m_cnt++;
        end else if (m_cnt == 15) begin
          m_cnt = 0;
          if (m_st == 2) begin
            m_word = m_word | (m_s2 << m_idx);
            if (m_idx == m_len - 1) m_st = 3;
            m_idx++;
          end else begin
            m_out = m_word; m_valid = 1; sf = (m_s2 == 0); m_st = 0;
          end
        end else m_cnt++;
      end
      if (sn) m_ne = 1; else if (clr_b) m_ne = 0;
      if (sf) m_fe = 1; else if (clr_b) m_fe = 0;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = rx_b;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison and word monitor
  int words = 0;
  int last_word = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 data_valid_o", int'(valid_o), m_valid);
      chk("R4 data_o", int'(data_o), m_out);
      chk("R3 noise_err_o", int'(noise_o), m_ne);
      chk("R7 frame_err_o", int'(frame_o), m_fe);
      if (valid_o) begin words++; last_word = int'(data_o); end
    end
  end

  task automatic send_frame(input logic [8:0] d, input int nb, input logic stop);
    rx_b = 1'b0; repeat (BIT_CLK) @(negedge clk);
    for (int i = 0; i < nb; i++) begin rx_b = d[i]; repeat (BIT_CLK) @(negedge clk); end
    rx_b = stop; repeat (BIT_CLK) @(negedge clk);
    rx_b = 1'b1; repeat (2 * BIT_CLK) @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr_b = 1'b1; @(negedge clk); clr_b = 1'b0; @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int w0;
    repeat (5) @(negedge clk);
    // R1
    chk("R1 reset data_o", int'(data_o), 0);
    chk("R1 reset flags", int'({valid_o, noise_o, frame_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'({valid_o, noise_o, frame_o}), 0);
    en_b = 1'b1;
    repeat (BIT_CLK) @(negedge clk);

    // R4 8-bit LSB first
    len_b = 2'd1;
    send_frame(9'h0A5, 8, 1'b1); chk("R4 word A5", last_word, 'hA5);
    send_frame(9'h03C, 8, 1'b1); chk("R4 word 3C", last_word, 'h3C);
    // R5 lengths
    len_b = 2'd0;
    send_frame(9'h1D5, 7, 1'b1); chk("R5 7-bit word", last_word, 'h55);
    len_b = 2'd2;
    send_frame(9'h1A3, 9, 1'b1); chk("R5 9-bit word", last_word, 'h1A3);
    len_b = 2'd3;
    send_frame(9'h081, 8, 1'b1); chk("R5 code3 8-bit", last_word, 'h81);
    chk("R6 word count", words, 5);

    // R7 framing error still delivers
    len_b = 2'd1;
    send_frame(9'h05A, 8, 1'b0);
    chk("R7 word with bad stop", last_word, 'h5A);
    chk("R7 frame flag", int'(frame_o), 1);
    chk("R7 count", words, 6);
    // R8 sticky then clear
    repeat (3 * BIT_CLK) @(negedge clk);
    chk("R8 frame sticky", int'(frame_o), 1);
    pulse_clr();
    chk("R8 frame cleared", int'(frame_o), 0);

    // R3 glitch rejected
    w0 = words;
    rx_b = 1'b0; repeat (12) @(negedge clk);
    rx_b = 1'b1; repeat (2 * BIT_CLK) @(negedge clk);
    chk("R3 noise flag", int'(noise_o), 1);
    chk("R3 no word", words, w0);
    send_frame(9'h0C3, 8, 1'b1);
    chk("R3 recovers", last_word, 'hC3);
    chk("R8 noise sticky", int'(noise_o), 1);
    pulse_clr();
    chk("R8 noise cleared", int'(noise_o), 0);

    // R9 abort mid-frame
    w0 = words;
    rx_b = 1'b0; repeat (3 * BIT_CLK) @(negedge clk);
    en_b = 1'b0;
    repeat (7 * BIT_CLK) @(negedge clk);
    rx_b = 1'b1; repeat (2 * BIT_CLK) @(negedge clk);
    // R9 edges ignored while disabled
    send_frame(9'h055, 8, 1'b1);
    chk("R9 no word", words, w0);
    en_b = 1'b1; @(negedge clk);
    // R2 enabled again, normal reception
    send_frame(9'h096, 8, 1'b1);
    chk("R2 word after enable", last_word, 'h96);
    chk("R2 count", words, w0 + 1);
    finish_run();
  end
endmodule